// File: doc/BRIEF.md
# Request/Grant Bus Hand-Over Arbiter

This block lets up to two alternate bus masters take the local bus from the processor. Each master has one active-low request/grant wire with a weak pull-up. The wire carries three one-clock low pulses in turn: a request from the master, a grant from the processor, and a release from the master. The block watches each wire and ignores the pulses it drives itself. It latches requests and decides in which clock the processor may let go of the bus. It then pulls the chosen wire low for the one grant clock and floats the bus from the next clock until the owner's release pulse arrives. After each exchange it always inserts one recovery clock.

The bus sequencer reports the current bus state and the attributes of the running cycle. A grant is issued only in an idle clock or at the end state of a cycle. At the end state, the request must have been seen no later than the second state of that cycle. The cycle must not be the low half of a split word transfer, and it must not be the first acknowledge of an interrupt-acknowledge pair. While a locked instruction runs, no grant is issued at all. When both wires are waiting, the lower-numbered channel wins. A request that arrives during another master's tenure stays pending and is served once the recovery clock has passed.

Top module: `rqgt_arbiter`

## Requirements
- R1: While rst_ni is low, and right after it rises, line_pd_o is all zero and float_o is 0.
- R2: A request is a line_i[c] low sample at a rising edge in which the block is not pulling that line low. Only one pulse is needed. If the next clock is idle (tstate_i = 5) and lock_ni is high, line_pd_o[c] is 1 in that clock, for exactly one clock.
- R3: float_o is 1 from the clock after a grant through the clock in which the owner's line is sampled low. It returns to 0 in the following clock.
- R4: The clock after float_o falls is a recovery clock, and no grant is issued in it.
- R5: When both channels are pending and a grant is allowed, channel 0 receives it.
- R6: A request captured at the edge that ends a T3 (tstate_i = 2) or Tw (tstate_i = 4) clock is not granted at the T4 (tstate_i = 3) of the same cycle. It is granted at a later T4 or idle clock. A request captured at the end of T1 (0) or T2 (1) can be granted at that cycle's T4.
- R7: Grants occur only when tstate_i is 3 or 5. At T4, no grant is issued while low_byte_i or inta_first_i is 1, and the request stays pending.
- R8: While lock_ni is 0, line_pd_o stays zero. The request stays pending and is granted once lock_ni is high in a grant-capable clock.
- R9: A request on the non-owner channel during a hold is kept pending. It is granted in the first clock after the recovery clock.
- R10: The block's own grant pulse is never taken as a request. After an exchange with no new request, no further grant follows.
- R11: At most one line_pd_o bit is high in any clock, and none is high while float_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NCH | Sampled level of each request/grant wire (low = pulse) |
| tstate_i | input | 3 | Bus state: 0 T1, 1 T2, 2 T3, 3 T4, 4 Tw, 5 idle |
| low_byte_i | input | 1 | Running cycle is the low half of a word transfer |
| inta_first_i | input | 1 | Running cycle is the first interrupt acknowledge |
| lock_ni | input | 1 | Locked instruction in progress when low |
| line_pd_o | output | NCH | Pull-down enable per wire (grant pulse) |
| float_o | output | 1 | Bus and control lines floated for an alternate master |

## Verification
The checker watches several rules on every clock. It checks that grant pulses are one-hot and one clock wide, and that they fall only in T4 or idle clocks. It checks that no grant appears under lock, during a float, in the recovery clock, or at a blocked T4, and that float follows every grant. The rules that depend on timing and history can only be shown by bench scenarios. These are the early/late request window across T2 and T3/Tw, fixed priority between simultaneous requests, and a pending request carried over another master's hold. They also include the block ignoring its own pulse, and a sweep of every bus state against every attribute combination.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [2:0] {
    TS_T1 = 3'd0,
    TS_T2 = 3'd1,
    TS_T3 = 3'd2,
    TS_T4 = 3'd3,
    TS_TW = 3'd4,
    TS_TI = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    OWN_OPEN  = 2'd0,
    OWN_HELD  = 2'd1,
    OWN_RECOV = 2'd2
  } own_state_e;
endpackage

// File: rtl/rg_chan_tracker.sv
module rg_chan_tracker
  import rg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pulse_i,
  input  logic    held_by_me_i,
  input  logic    grant_i,
  input  tstate_e tstate_i,
  output logic    pend_o,
  output logic    early_o
);
  logic pend_q, early_q;
  logic late_slot;

  assign late_slot = (tstate_i == TS_T3) || (tstate_i == TS_TW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      early_q <= 1'b0;
    end else if (grant_i) begin
      pend_q  <= 1'b0;
      early_q <= 1'b0;
    end else if (pulse_i && !held_by_me_i && !pend_q) begin
      pend_q  <= 1'b1;
      early_q <= !late_slot;
    end else if (pend_q && tstate_i == TS_T4) begin
      // a cycle boundary passed: the request now predates the next T2
      early_q <= 1'b1;
    end
  end

  assign pend_o  = pend_q;
  assign early_o = early_q;
endmodule

// File: rtl/rg_release_gate.sv
module rg_release_gate
  import rg_pkg::*;
#(
  parameter int NCH = 2
) (
  input  tstate_e        tstate_i,
  input  logic           low_byte_i,
  input  logic           inta_first_i,
  input  logic           lock_ni,
  input  logic           open_i,
  input  logic [NCH-1:0] pend_i,
  input  logic [NCH-1:0] early_i,
  output logic [NCH-1:0] grant_o
);
  logic [NCH-1:0] elig;
  logic           t4_ok;

  assign t4_ok = (tstate_i == TS_T4) && !low_byte_i && !inta_first_i;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      elig[c] = pend_i[c] && open_i && lock_ni &&
                ((tstate_i == TS_TI) || (t4_ok && early_i[c]));
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    logic taken;
    taken   = 1'b0;
    grant_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (elig[c] && !taken) begin
        grant_o[c] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rg_owner_fsm.sv
module rg_owner_fsm
  import rg_pkg::*;
#(
  parameter int NCH = 2,
  localparam int OW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] grant_i,
  input  logic [NCH-1:0] pulse_i,
  output logic           open_o,
  output logic           float_o,
  output logic [NCH-1:0] held_by_o
);
  own_state_e     state_q, state_d;
  logic [OW-1:0]  owner_q, owner_d;
  logic [OW-1:0]  grant_idx;

  always_comb begin
    grant_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (grant_i[c]) grant_idx = OW'(c);
    end
  end

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    unique case (state_q)
      OWN_OPEN: if (|grant_i) begin
        state_d = OWN_HELD;
        owner_d = grant_idx;
      end
      OWN_HELD: if (pulse_i[owner_q]) state_d = OWN_RECOV;
      OWN_RECOV: state_d = OWN_OPEN;
      default: state_d = OWN_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OWN_OPEN;
      owner_q <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
    end
  end

  assign open_o  = (state_q == OWN_OPEN);
  assign float_o = (state_q == OWN_HELD);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      held_by_o[c] = float_o && (owner_q == OW'(c));
    end
  end
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
  import rg_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] line_i,
  input  logic [2:0]     tstate_i,
  input  logic           low_byte_i,
  input  logic           inta_first_i,
  input  logic           lock_ni,
  output logic [NCH-1:0] line_pd_o,
  output logic           float_o
);
  tstate_e        ts;
  logic [NCH-1:0] pulse, pend, early, grant, held_by;
  logic           open_st;

  assign ts = tstate_e'(tstate_i);
  // a low wire we are not pulling down is a pulse from the far master
  assign pulse = ~line_i & ~grant;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rg_chan_tracker u_trk (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pulse_i      (pulse[c]),
      .held_by_me_i (held_by[c]),
      .grant_i      (grant[c]),
      .tstate_i     (ts),
      .pend_o       (pend[c]),
      .early_o      (early[c])
    );
  end

  rg_release_gate #(.NCH(NCH)) u_gate (
    .tstate_i     (ts),
    .low_byte_i   (low_byte_i),
    .inta_first_i (inta_first_i),
    .lock_ni      (lock_ni),
    .open_i       (open_st),
    .pend_i       (pend),
    .early_i      (early),
    .grant_o      (grant)
  );

  rg_owner_fsm #(.NCH(NCH)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grant_i   (grant),
    .pulse_i   (pulse),
    .open_o    (open_st),
    .float_o   (float_o),
    .held_by_o (held_by)
  );

  assign line_pd_o = grant;
endmodule

// File: rtl/rg_arbiter_checks.sv
module rg_arbiter_checks #(
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     tstate_i,
  input logic           low_byte_i,
  input logic           inta_first_i,
  input logic           lock_ni,
  input logic [NCH-1:0] line_pd_o,
  input logic           float_o
);
  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_pd_o));

  p_no_grant_in_float_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_o |-> (line_pd_o == '0));

  p_grant_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pd_o != '0) |-> (tstate_i == 3'd3 || tstate_i == 3'd5));

  p_t4_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((line_pd_o != '0) && tstate_i == 3'd3) |-> (!low_byte_i && !inta_first_i));

  p_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_ni |-> (line_pd_o == '0));

  p_one_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pd_o != '0) |=> (line_pd_o == '0));

  p_float_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pd_o != '0) |=> float_o);

  p_recovery_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(float_o) |-> (line_pd_o == '0));
endmodule

bind rqgt_arbiter rg_arbiter_checks #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tstate_i     (tstate_i),
  .low_byte_i   (low_byte_i),
  .inta_first_i (inta_first_i),
  .lock_ni      (lock_ni),
  .line_pd_o    (line_pd_o),
  .float_o      (float_o)
);

// File: tb/rqgt_arbiter_tb.sv
module rqgt_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ts;
  logic       lb, ia, lk_n;
  logic [1:0] mdrv;
  wire  [1:0] line;
  logic [1:0] pd;
  logic       flt;
  int checks = 0, fails = 0;

  localparam logic [2:0] T1 = 3'd0, T2 = 3'd1, T3 = 3'd2, T4 = 3'd3, TW = 3'd4, TI = 3'd5;

  always #4 clk = ~clk;

  assign line = ~(mdrv | pd);

  rqgt_arbiter #(.NCH(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tstate_i(ts),
    .low_byte_i(lb), .inta_first_i(ia), .lock_ni(lk_n),
    .line_pd_o(pd), .float_o(flt)
  );

  task automatic expect_o(input string req, input logic [1:0] epd, input logic eflt);
    checks++;
    if (pd !== epd || flt !== eflt) begin
      fails++;
      $display("FAIL %s: got pd=%b float=%b expected pd=%b float=%b", req, pd, flt, epd, eflt);
    end
  endtask

  task automatic cyc(input logic [2:0] t, input logic [1:0] m,
                     input logic b = 1'b0, input logic a = 1'b0, input logic k = 1'b1);
    @(negedge clk);
    ts = t; mdrv = m; lb = b; ia = a; lk_n = k;
    #1;
  endtask

  task automatic finish_hold(input int ch);
    cyc(TI, 2'b00);        expect_o("R3 float held", 2'b00, 1'b1);
    cyc(TI, 2'(1 << ch));  expect_o("R3 float until release", 2'b00, 1'b1);
    cyc(TI, 2'b00);        expect_o("R4 recovery clock", 2'b00, 1'b0);
    cyc(TI, 2'b00);        expect_o("R10 no self-request", 2'b00, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ts = TI; mdrv = 2'b00; lb = 0; ia = 0; lk_n = 1;
    repeat (3) @(negedge clk);
    #1 expect_o("R1 in reset", 2'b00, 1'b0);
    mdrv = 2'b01;  // pulse during reset must be lost
    @(negedge clk); mdrv = 2'b00; rst_n = 1'b1; #1;
    expect_o("R1 after reset", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R1 idle", 2'b00, 1'b0);

    // R2/R3/R4/R10: single request in idle
    cyc(TI, 2'b01); expect_o("R2 request clock", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R2 grant pulse", 2'b01, 1'b0);
    finish_hold(0);

    // R5: both request together
    cyc(TI, 2'b11); expect_o("R5 request clock", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R5 ch0 first", 2'b01, 1'b0);
    cyc(TI, 2'b00); expect_o("R3 hold ch0", 2'b00, 1'b1);
    cyc(TI, 2'b01); expect_o("R3 release ch0", 2'b00, 1'b1);
    cyc(TI, 2'b00); expect_o("R4 recovery before ch1", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R5 ch1 next", 2'b10, 1'b0);
    finish_hold(1);

    // R9: ch1 requests during ch0 hold
    cyc(TI, 2'b01); cyc(TI, 2'b00); expect_o("R9 ch0 grant", 2'b01, 1'b0);
    cyc(TI, 2'b10); expect_o("R9 ch1 pulse no release", 2'b00, 1'b1);
    cyc(TI, 2'b00); expect_o("R9 still held", 2'b00, 1'b1);
    cyc(TI, 2'b01); expect_o("R9 owner release", 2'b00, 1'b1);
    cyc(TI, 2'b00); expect_o("R4 recovery", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R9 pending ch1 served", 2'b10, 1'b0);
    finish_hold(1);

    // R6: late request in T3
    cyc(T1, 2'b00); cyc(T2, 2'b00);
    cyc(T3, 2'b01); expect_o("R7 no grant T3", 2'b00, 1'b0);
    cyc(T4, 2'b00); expect_o("R6 late T3 not at T4", 2'b00, 1'b0);
    cyc(T1, 2'b00); expect_o("R7 no grant T1", 2'b00, 1'b0);
    cyc(T2, 2'b00); expect_o("R7 no grant T2", 2'b00, 1'b0);
    cyc(T3, 2'b00);
    cyc(T4, 2'b00); expect_o("R6 granted next T4", 2'b01, 1'b0);
    finish_hold(0);

    // R6: request in T2 is early
    cyc(T1, 2'b00); cyc(T2, 2'b01); cyc(T3, 2'b00);
    cyc(T4, 2'b00); expect_o("R6 T2 request same T4", 2'b01, 1'b0);
    finish_hold(0);

    // R6: late request in Tw
    cyc(T3, 2'b00); cyc(TW, 2'b01);
    cyc(TW, 2'b00); expect_o("R7 no grant Tw", 2'b00, 1'b0);
    cyc(T4, 2'b00); expect_o("R6 late Tw not at T4", 2'b00, 1'b0);
    cyc(TI, 2'b00); expect_o("R6 granted in idle", 2'b01, 1'b0);
    finish_hold(0);

    // R7: blocked T4s
    cyc(T1, 2'b01); cyc(T2, 2'b00); cyc(T3, 2'b00);
    cyc(T4, 2'b00, 1'b1); expect_o("R7 low byte blocks", 2'b00, 1'b0);
    cyc(T1, 2'b00); cyc(T2, 2'b00); cyc(T3, 2'b00);
    cyc(T4, 2'b00, 1'b0, 1'b1); expect_o("R7 first inta blocks", 2'b00, 1'b0);
    cyc(T1, 2'b00); cyc(T2, 2'b00); cyc(T3, 2'b00);
    cyc(T4, 2'b00); expect_o("R7 clean T4 grants", 2'b01, 1'b0);
    finish_hold(0);

    // R8: lock
    cyc(TI, 2'b01, 0, 0, 0); expect_o("R8 locked", 2'b00, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc(TI, 2'b00, 0, 0, 0); expect_o("R8 locked no grant", 2'b00, 1'b0);
    end
    cyc(TI, 2'b00); expect_o("R8 grant after unlock", 2'b01, 1'b0);
    finish_hold(0);

    // R7/R8 sweep: every bus state against every attribute mix
    for (int t = 0; t <= 5; t++) begin
      for (int b = 0; b < 8; b++) begin
        logic g;
        g = b[2] && (t == 5 || (t == 3 && !b[0] && !b[1]));
        cyc(T1, 2'b01);
        cyc(3'(t), 2'b00, b[0], b[1], b[2]);
        expect_o("R7 R8 sweep", {1'b0, g}, 1'b0);
        if (!g) begin
          cyc(TI, 2'b00); expect_o("R7 sweep pending kept", 2'b01, 1'b0);
        end
        finish_hold(0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule